// File: doc/BRIEF.md
# Serial Display Link Controller

This block is a serial master that sends commands and pixel or register data to a display panel and reads data back from it. A host loads a set of configuration inputs, presents the first write word, and pulses `start`. The controller then lowers the active-low chip select, waits one serial bit period, and sends a frame made of three parts. The first part is an optional preamble whose length and contents the host chooses. The second is a short header that carries the read/write flag and the register-select flag. The third is one data word or a burst of words. After the last bit it waits one more bit period and then releases chip select.

Four wiring modes are supported. The 3-wire mode uses one shared data line. Inside the block, data in and data out stay separate, and an output-enable tells the pad mux when to drive the shared line. The 4-wire mode has a separate data input and a separate data output. The two 5-wire modes take the register-select flag out of the serial stream and put it on a dedicated line. In one 5-wire mode that line is valid only while chip select is low, so the panel samples it with the serial clock. In the other it is set up before chip select falls and stays put after it rises, so the panel can sample it on chip select.

The serial clock comes from the system clock through a programmable divider. A polarity input selects whether the clock idles low (straight) or high (inverted).

Top module: `sdi_ctrl`

## Requirements
- R1: After reset, `sd_cs_n` is 1, and `busy`, `sd_oe`, `rd_valid` and `wr_take` are 0. While idle, `sd_clk` follows `cfg_clk_pol`.
- R2: A `start` seen while idle begins a transfer. `busy` rises in the same cycle as `sd_cs_n` falls and falls in the same cycle as `sd_cs_n` rises. A `start` while `busy` is high is ignored: it neither changes the frame in progress nor causes a second one.
- R3: Each serial bit lasts 2*(`cfg_div`+1) system clocks. The first sampling edge comes 3*(`cfg_div`+1) clocks after `sd_cs_n` falls, and `sd_cs_n` rises 3*(`cfg_div`+1) clocks after the last sampling edge.
- R4: The preamble sends `cfg_pre_len` bits of `cfg_pre_bits`, from bit `cfg_pre_len`-1 down to bit 0. A length of 0 sends no preamble, and any length above 16 is treated as 16.
- R5: In 3-wire and 4-wire modes the header is two bits, RW then RS when `cfg_rs_first`=0 and RS then RW when it is 1. RW is 1 for a read (`cmd_read`=1) and 0 for a write.
- R6: With `cfg_rw_en`=0 the RW bit is left out, and only RS (or, in 5-wire modes, nothing) precedes the data.
- R7: Mode codes are 0 for 3-wire, 1 for 4-wire, 2 for 5-wire clock-sampled and 3 for 5-wire select-sampled. In modes 2 and 3, RS is not sent serially and `sd_rs` equals `cmd_rs` during the frame. In mode 2, `sd_rs` is 0 once `sd_cs_n` is high. In mode 3 it keeps its value after the frame ends. In modes 0 and 1, `sd_rs` is 0.
- R8: Data is sent most significant bit first. `cmd_len_m1`+1 words (1 to 256) are sent within one chip-select low period. `wr_take` pulses for one cycle as each write word is taken from `wr_data`, and the host then presents the next word.
- R9: On a read, `sd_di` is sampled on each sampling edge, MSB first. After each 8th bit, `rd_data` holds the word and `rd_valid` pulses for one cycle.
- R10: In 3-wire mode, `sd_oe` is 1 while `sd_cs_n` is low, except during the data phase of a read, where it is 0. In all other modes, and while idle, `sd_oe` is 0.
- R11: The sampling edge is the `sd_clk` transition away from its idle level `cfg_clk_pol`. Data changes only on the opposite transition, or while the clock idles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| cfg_mode | input | 2 | Wiring mode: 0 3-wire, 1 4-wire, 2 5-wire clock-sampled, 3 5-wire select-sampled |
| cfg_pre_len | input | PRE_LW (5) | Preamble length in bits, 0 to 16 |
| cfg_pre_bits | input | PRE_MAX (16) | Preamble contents |
| cfg_rs_first | input | 1 | 1: RS precedes RW |
| cfg_rw_en | input | 1 | 1: RW bit is sent |
| cfg_clk_pol | input | 1 | Idle level of the serial clock |
| cfg_div | input | DIV_W (8) | Half-bit length minus one, in system clocks |
| cmd_read | input | 1 | 1: read transfer |
| cmd_rs | input | 1 | Register-select value |
| cmd_len_m1 | input | BURST_W (8) | Number of words minus one |
| wr_data | input | DATA_W (8) | Current write word |
| wr_take | output | 1 | Write word consumed |
| rd_data | output | DATA_W (8) | Last received word |
| rd_valid | output | 1 | `rd_data` updated |
| busy | output | 1 | Transfer in progress |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_clk | output | 1 | Serial clock |
| sd_do | output | 1 | Serial data out |
| sd_di | input | 1 | Serial data in |
| sd_oe | output | 1 | Drive enable for a shared data line |
| sd_rs | output | 1 | Dedicated register-select line (5-wire modes) |

## Verification
The bench builds the expected frame bit by bit for each setup. The setups cover a preamble of length 0, 8, 16 and 20, both header orders, a missing RW bit, and a burst of 256 words. A design that miscounts the preamble clamp or the burst end would leave expected bits unconsumed or emit extra ones. Read frames in 3-wire mode check that the output-enable drops exactly for the data phase, and a design that kept driving would show `sd_oe` high on a read data bit. The lead and trail gaps and the bit period are measured against the divider, which catches an off-by-one tick count. A start pulse in the middle of a frame, carrying different settings, must leave the stream untouched. The two 5-wire modes must differ only in what `sd_rs` does after chip select rises.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  typedef enum logic [1:0] {
    M_3W     = 2'd0,
    M_4W     = 2'd1,
    M_5W_CLK = 2'd2,
    M_5W_CS  = 2'd3
  } sdi_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_PRE   = 3'd2,
    ST_HDR   = 3'd3,
    ST_DATA  = 3'd4,
    ST_TRAIL = 3'd5
  } sdi_state_e;
endpackage

// File: rtl/sdi_tick.sv
module sdi_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdi_hdr.sv
module sdi_hdr
  import sdi_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       rw_en,
  input  logic       rs_first,
  input  logic       rw,
  input  logic       rs,
  output logic [1:0] bits,
  output logic [1:0] n
);
  logic rs_serial;
  assign rs_serial = (mode == M_3W) || (mode == M_4W);

  always_comb begin
    bits = 2'b00;
    n    = 2'd0;
    if (rs_serial && rw_en) begin
      bits = rs_first ? {rs, rw} : {rw, rs};
      n    = 2'd2;
    end else if (rs_serial) begin
      bits = {1'b0, rs};
      n    = 2'd1;
    end else if (rw_en) begin
      bits = {1'b0, rw};
      n    = 2'd1;
    end
  end
endmodule

// File: rtl/sdi_engine.sv
module sdi_engine
  import sdi_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int PRE_MAX = 16,
  parameter int BURST_W = 8,
  parameter int PRE_LW  = $clog2(PRE_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [1:0]         cfg_mode,
  input  logic [PRE_LW-1:0]  cfg_pre_len,
  input  logic [PRE_MAX-1:0] cfg_pre_bits,
  input  logic               cfg_clk_pol,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               cmd_read,
  input  logic               cmd_rs,
  input  logic [BURST_W-1:0] cmd_len_m1,
  input  logic [1:0]         hdr_bits,
  input  logic [1:0]         hdr_n,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               sd_di,
  input  logic               tick,
  output logic [DIV_W-1:0]   div_q,
  output logic               wr_take,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               busy,
  output logic               sd_cs_n,
  output logic               sd_clk,
  output logic               sd_do,
  output logic               sd_oe,
  output logic               sd_rs
);
  localparam int PIDX_W = (PRE_MAX > 1) ? $clog2(PRE_MAX) : 1;
  localparam int DIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int IDX_W  = (PIDX_W > DIDX_W) ? PIDX_W : DIDX_W;

  sdi_state_e          state, nx_state;
  logic                half;
  logic [PRE_MAX-1:0]  pre_q;
  logic [PRE_LW-1:0]   pre_len_q, pre_len_eff;
  logic [IDX_W-1:0]    idx, nx_idx;
  logic [1:0]          hdr_q, hdr_n_q, hdr_left, nx_hdr_left;
  logic [BURST_W-1:0]  words_left, nx_words;
  logic [DATA_W-1:0]   word_q, rd_sh;
  logic                rw_q, pol_q, nx_load, nx_do, nx_oe;
  logic [1:0]          mode_q;

  assign pre_len_eff = (cfg_pre_len > PRE_LW'(PRE_MAX)) ? PRE_LW'(PRE_MAX) : cfg_pre_len;

  // Slot sequencer: what the next bit slot is when the current one ends.
  always_comb begin
    nx_state    = state;
    nx_idx      = idx;
    nx_hdr_left = hdr_left;
    nx_words    = words_left;
    nx_load     = 1'b0;
    case (state)
      ST_LEAD: begin
        if (pre_len_q != '0) begin
          nx_state = ST_PRE;
          nx_idx   = IDX_W'(pre_len_q - 1'b1);
        end else if (hdr_n_q != 2'd0) begin
          nx_state    = ST_HDR;
          nx_hdr_left = hdr_n_q;
        end else begin
          nx_state = ST_DATA;
          nx_load  = 1'b1;
        end
      end
      ST_PRE: begin
        if (idx != '0) begin
          nx_idx = idx - 1'b1;
        end else if (hdr_n_q != 2'd0) begin
          nx_state    = ST_HDR;
          nx_hdr_left = hdr_n_q;
        end else begin
          nx_state = ST_DATA;
          nx_load  = 1'b1;
        end
      end
      ST_HDR: begin
        if (hdr_left == 2'd1) begin
          nx_state = ST_DATA;
          nx_load  = 1'b1;
        end else begin
          nx_hdr_left = hdr_left - 1'b1;
        end
      end
      ST_DATA: begin
        if (idx != '0) begin
          nx_idx = idx - 1'b1;
        end else if (words_left == '0) begin
          nx_state = ST_TRAIL;
        end else begin
          nx_words = words_left - 1'b1;
          nx_load  = 1'b1;
        end
      end
      default: ;
    endcase
    if (nx_load) nx_idx = IDX_W'(DATA_W - 1);
  end

  always_comb begin
    case (nx_state)
      ST_PRE:  nx_do = pre_q[nx_idx[PIDX_W-1:0]];
      ST_HDR:  nx_do = (nx_hdr_left == 2'd2) ? hdr_q[1] : hdr_q[0];
      ST_DATA: nx_do = rw_q ? 1'b0 :
                       (nx_load ? wr_data[DATA_W-1] : word_q[nx_idx[DIDX_W-1:0]]);
      default: nx_do = 1'b0;
    endcase
    nx_oe = (mode_q == M_3W) && !((nx_state == ST_DATA) && rw_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      half       <= 1'b0;
      pre_q      <= '0;
      pre_len_q  <= '0;
      idx        <= '0;
      hdr_q      <= '0;
      hdr_n_q    <= '0;
      hdr_left   <= '0;
      words_left <= '0;
      word_q     <= '0;
      rd_sh      <= '0;
      rw_q       <= 1'b0;
      pol_q      <= 1'b0;
      mode_q     <= 2'd0;
      div_q      <= '0;
      wr_take    <= 1'b0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      busy       <= 1'b0;
      sd_cs_n    <= 1'b1;
      sd_clk     <= 1'b0;
      sd_do      <= 1'b0;
      sd_oe      <= 1'b0;
      sd_rs      <= 1'b0;
    end else begin
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      if (state == ST_IDLE) begin
        sd_clk <= cfg_clk_pol;
        if (start) begin
          state      <= ST_LEAD;
          half       <= 1'b0;
          pre_q      <= cfg_pre_bits;
          pre_len_q  <= pre_len_eff;
          hdr_q      <= hdr_bits;
          hdr_n_q    <= hdr_n;
          words_left <= cmd_len_m1;
          rw_q       <= cmd_read;
          pol_q      <= cfg_clk_pol;
          mode_q     <= cfg_mode;
          div_q      <= cfg_div;
          busy       <= 1'b1;
          sd_cs_n    <= 1'b0;
          sd_do      <= 1'b0;
          sd_oe      <= (cfg_mode == M_3W);
          sd_rs      <= (cfg_mode == M_5W_CLK || cfg_mode == M_5W_CS) ? cmd_rs : 1'b0;
        end
      end else if (tick) begin
        if (!half) begin
          half <= 1'b1;
          if (state == ST_PRE || state == ST_HDR || state == ST_DATA) sd_clk <= ~pol_q;
          if (state == ST_DATA && rw_q) begin
            rd_sh <= {rd_sh[DATA_W-2:0], sd_di};
            if (idx == '0) begin
              rd_data  <= {rd_sh[DATA_W-2:0], sd_di};
              rd_valid <= 1'b1;
            end
          end
        end else begin
          half   <= 1'b0;
          sd_clk <= pol_q;
          if (state == ST_TRAIL) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            sd_cs_n <= 1'b1;
            sd_do   <= 1'b0;
            sd_oe   <= 1'b0;
            if (mode_q != M_5W_CS) sd_rs <= 1'b0;
          end else begin
            state      <= nx_state;
            idx        <= nx_idx;
            hdr_left   <= nx_hdr_left;
            words_left <= nx_words;
            sd_do      <= nx_do;
            sd_oe      <= nx_oe;
            if (nx_load && !rw_q) begin
              word_q  <= wr_data;
              wr_take <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sdi_ctrl.sv
module sdi_ctrl
  import sdi_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int PRE_MAX = 16,
  parameter int BURST_W = 8,
  parameter int PRE_LW  = $clog2(PRE_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [1:0]         cfg_mode,
  input  logic [PRE_LW-1:0]  cfg_pre_len,
  input  logic [PRE_MAX-1:0] cfg_pre_bits,
  input  logic               cfg_rs_first,
  input  logic               cfg_rw_en,
  input  logic               cfg_clk_pol,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               cmd_read,
  input  logic               cmd_rs,
  input  logic [BURST_W-1:0] cmd_len_m1,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               wr_take,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               busy,
  output logic               sd_cs_n,
  output logic               sd_clk,
  output logic               sd_do,
  input  logic               sd_di,
  output logic               sd_oe,
  output logic               sd_rs
);
  logic [1:0]       hdr_bits, hdr_n;
  logic [DIV_W-1:0] div_q;
  logic             tick;

  sdi_hdr u_hdr (
    .mode     (cfg_mode),
    .rw_en    (cfg_rw_en),
    .rs_first (cfg_rs_first),
    .rw       (cmd_read),
    .rs       (cmd_rs),
    .bits     (hdr_bits),
    .n        (hdr_n)
  );

  sdi_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (div_q),
    .tick (tick)
  );

  sdi_engine #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .PRE_MAX(PRE_MAX),
    .BURST_W(BURST_W),
    .PRE_LW (PRE_LW)
  ) u_eng (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cfg_mode    (cfg_mode),
    .cfg_pre_len (cfg_pre_len),
    .cfg_pre_bits(cfg_pre_bits),
    .cfg_clk_pol (cfg_clk_pol),
    .cfg_div     (cfg_div),
    .cmd_read    (cmd_read),
    .cmd_rs      (cmd_rs),
    .cmd_len_m1  (cmd_len_m1),
    .hdr_bits    (hdr_bits),
    .hdr_n       (hdr_n),
    .wr_data     (wr_data),
    .sd_di       (sd_di),
    .tick        (tick),
    .div_q       (div_q),
    .wr_take     (wr_take),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .busy        (busy),
    .sd_cs_n     (sd_cs_n),
    .sd_clk      (sd_clk),
    .sd_do       (sd_do),
    .sd_oe       (sd_oe),
    .sd_rs       (sd_rs)
  );
endmodule

// File: rtl/sdi_ctrl_chk.sv
module sdi_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cfg_clk_pol,
  input logic busy,
  input logic sd_cs_n,
  input logic sd_clk,
  input logic sd_oe,
  input logic rd_valid,
  input logic wr_take
);
  AST_SELECT_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n |-> busy); // R2

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R2

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    sd_cs_n |-> !sd_oe); // R10

  AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (sd_cs_n && $past(sd_cs_n) && !$past(rst)) |-> (sd_clk == $past(cfg_clk_pol))); // R11

  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R9

  AST_TAKE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> (busy && !sd_cs_n)); // R8
endmodule

bind sdi_ctrl sdi_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .cfg_clk_pol(cfg_clk_pol),
  .busy       (busy),
  .sd_cs_n    (sd_cs_n),
  .sd_clk     (sd_clk),
  .sd_oe      (sd_oe),
  .rd_valid   (rd_valid),
  .wr_take    (wr_take)
);

// File: tb/sim_sdi_ctrl.sv
module sim_sdi_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [4:0]  cfg_pre_len = '0;
  logic [15:0] cfg_pre_bits = '0;
  logic        cfg_rs_first = 1'b0, cfg_rw_en = 1'b1, cfg_clk_pol = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic        cmd_read = 1'b0, cmd_rs = 1'b0;
  logic [7:0]  cmd_len_m1 = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_take;
  logic [7:0]  rd_data;
  logic        rd_valid, busy, sd_cs_n, sd_clk, sd_do, sd_oe, sd_rs;
  logic        sd_di = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdi_ctrl u0 (.*);

  int checks = 0, errors = 0;
  bit    exp_val[$];
  bit    exp_care[$];
  bit    exp_oe[$];
  string exp_tag[$];
  logic [7:0] exp_rd[$];
  logic [7:0] wq[$];
  bit    di_q[$];
  logic [7:0] word_buf[256];

  int  cur_div = 0;
  bit  cur_pol = 0, cur_rs = 0;
  logic [1:0] cur_mode = 0;
  longint cyc = 0, t_fall = 0, t_last = 0;
  bit  first_edge = 0, prev_cs = 1, prev_clk = 0;
  int  nfall = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: pops the scoreboard on each sampling edge.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
    if (!rst) begin
      if (prev_cs && !sd_cs_n) begin
        t_fall = cyc; first_edge = 1; nfall++;
      end
      if (!sd_cs_n && sd_clk != prev_clk && sd_clk == !cur_pol) begin
        if (first_edge)
          chk(cyc - t_fall == 3*(cur_div+1), "R3", "lead gap", cyc - t_fall, 3*(cur_div+1));
        else
          chk(cyc - t_last == 2*(cur_div+1), "R3", "bit period", cyc - t_last, 2*(cur_div+1));
        first_edge = 0;
        t_last = cyc;
        if (exp_val.size() == 0) begin
          chk(0, "R8", "extra bit", 1, 0);
        end else begin
          bit v, c, o;
          string tg;
          v = exp_val.pop_front(); c = exp_care.pop_front();
          o = exp_oe.pop_front(); tg = exp_tag.pop_front();
          if (c) chk(sd_do == v, tg, "data bit", sd_do, v);
          chk(sd_oe == o, (c ? "R10" : "R10 read"), "oe", sd_oe, o);
          if (!c && di_q.size() > 0) begin
            void'(di_q.pop_front());
            sd_di = (di_q.size() > 0) ? di_q[0] : 1'b0;
          end
        end
        if (cur_mode >= 2) chk(sd_rs == cur_rs, "R7", "rs line in frame", sd_rs, cur_rs);
      end
      if (!prev_cs && sd_cs_n)
        chk(cyc - t_last == 3*(cur_div+1), "R3", "trail gap", cyc - t_last, 3*(cur_div+1));
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(0, "R9", "unexpected read word", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rd.pop_front();
          chk(rd_data == e, "R9", "read word", rd_data, e);
        end
      end
      if (wr_take && wq.size() > 0) wr_data = wq.pop_front();
    end
    prev_cs = sd_cs_n;
    prev_clk = sd_clk;
  end

  // Driver: builds the expected frame, then runs it.
  task automatic xfer(input logic [1:0] m, input int plen, input logic [15:0] pb,
                      input bit rsf, input bit rwen, input bit pol, input int dv,
                      input bit rd, input bit rs, input int nw, input bit poke);
    int  pl;
    bit  oe_on;
    int  f0;
    pl = (plen > 16) ? 16 : plen;
    oe_on = (m == 2'd0);
    for (int i = pl - 1; i >= 0; i--) begin
      exp_val.push_back(pb[i]); exp_care.push_back(1); exp_oe.push_back(oe_on); exp_tag.push_back("R4");
    end
    if (m < 2) begin
      if (rwen) begin
        bit a, b;
        a = rsf ? rs : rd; b = rsf ? rd : rs;
        exp_val.push_back(a); exp_care.push_back(1); exp_oe.push_back(oe_on); exp_tag.push_back("R5");
        exp_val.push_back(b); exp_care.push_back(1); exp_oe.push_back(oe_on); exp_tag.push_back("R5");
      end else begin
        exp_val.push_back(rs); exp_care.push_back(1); exp_oe.push_back(oe_on); exp_tag.push_back("R6");
      end
    end else if (rwen) begin
      exp_val.push_back(rd); exp_care.push_back(1); exp_oe.push_back(0); exp_tag.push_back("R7");
    end
    for (int w = 0; w < nw; w++) begin
      for (int b = 7; b >= 0; b--) begin
        if (rd) begin
          exp_val.push_back(0); exp_care.push_back(0); exp_oe.push_back(0); exp_tag.push_back("R9");
          di_q.push_back(word_buf[w][b]);
        end else begin
          exp_val.push_back(word_buf[w][b]); exp_care.push_back(1);
          exp_oe.push_back(oe_on); exp_tag.push_back("R8");
        end
      end
      if (rd) exp_rd.push_back(word_buf[w]); else wq.push_back(word_buf[w]);
    end
    @(negedge clk);
    cur_mode = m; cur_pol = pol; cur_div = dv; cur_rs = rs;
    cfg_mode = m; cfg_pre_len = 5'(plen); cfg_pre_bits = pb; cfg_rs_first = rsf;
    cfg_rw_en = rwen; cfg_clk_pol = pol; cfg_div = 8'(dv);
    cmd_read = rd; cmd_rs = rs; cmd_len_m1 = 8'(nw - 1);
    if (!rd) wr_data = wq.pop_front();
    sd_di = (di_q.size() > 0) ? di_q[0] : 1'b0;
    prev_clk = sd_clk;
    @(negedge clk);
    chk(sd_clk == pol, "R11", "idle clock level", sd_clk, pol);
    f0 = nfall;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1 && sd_cs_n == 0, "R2", "busy and select on start", {busy, sd_cs_n}, 2);
    if (poke) begin
      repeat (20) @(negedge clk);
      cfg_mode = 2'd1; cfg_pre_len = 5'd3; cmd_read = ~rd; cfg_clk_pol = ~pol;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
    chk(sd_cs_n == 1, "R2", "select high when idle", sd_cs_n, 1);
    repeat (4) @(negedge clk);
    chk(busy == 0, "R2", "stays idle", busy, 0);
    chk(nfall - f0 == 1, "R2", "one frame per start", nfall - f0, 1);
    chk(exp_val.size() == 0, "R8", "bits left unsent", exp_val.size(), 0);
    chk(exp_rd.size() == 0, "R9", "read words missing", exp_rd.size(), 0);
    if (m == 2'd3) chk(sd_rs == rs, "R7", "rs held after frame", sd_rs, rs);
    else chk(sd_rs == 0, "R7", "rs low after frame", sd_rs, 0);
    chk(sd_oe == 0, "R10", "oe low when idle", sd_oe, 0);
    exp_val.delete(); exp_care.delete(); exp_oe.delete(); exp_tag.delete();
    exp_rd.delete(); wq.delete(); di_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(sd_cs_n == 1, "R1", "reset select", sd_cs_n, 1);
    chk(busy == 0, "R1", "reset busy", busy, 0);
    chk(sd_oe == 0, "R1", "reset oe", sd_oe, 0);
    chk(rd_valid == 0 && wr_take == 0, "R1", "reset strobes", {rd_valid, wr_take}, 0);
    chk(sd_clk == 0, "R1", "reset clock level", sd_clk, 0);

    word_buf[0] = 8'h3C;
    xfer(2'd0, 8, 16'h00A5, 0, 1, 0, 1, 0, 1, 1, 0);      // R4 R5 R8 R10
    word_buf[0] = 8'h96; word_buf[1] = 8'h0F;
    xfer(2'd0, 0, 16'h0000, 1, 1, 0, 0, 1, 0, 2, 0);      // R5 R9 R10
    word_buf[0] = 8'h81; word_buf[1] = 8'h7E; word_buf[2] = 8'hC3;
    xfer(2'd1, 16, 16'hBEEF, 0, 0, 0, 2, 0, 1, 3, 0);     // R6 R4
    word_buf[0] = 8'h5A;
    xfer(2'd1, 20, 16'h1234, 1, 1, 1, 0, 0, 0, 1, 0);     // R4 clamp, R11
    word_buf[0] = 8'hF0; word_buf[1] = 8'h11;
    xfer(2'd2, 4, 16'h0009, 0, 1, 0, 1, 0, 1, 2, 0);      // R7 clock-sampled
    word_buf[0] = 8'hA7;
    xfer(2'd3, 0, 16'h0000, 0, 0, 1, 1, 1, 1, 1, 0);      // R7 select-sampled, R6
    word_buf[0] = 8'h24; word_buf[1] = 8'hDB;
    xfer(2'd1, 2, 16'h0002, 0, 1, 0, 1, 0, 0, 2, 1);      // R2 ignored start
    for (int i = 0; i < 256; i++) word_buf[i] = 8'(i*7 + 3);
    xfer(2'd0, 1, 16'h0001, 1, 1, 0, 0, 0, 1, 256, 0);    // R8 longest burst
    finish_run();
  end
endmodule